// File: doc/BRIEF.md
# Fully associative write-through byte cache

A small cache that sits between a requester and a slower byte-wide backing memory. Every entry holds one byte, so the address has no set-index or offset field: the whole request address is the tag, and the tag of every entry is compared against the request at once. A read that matches an entry completes in the same cycle it is presented, with no memory traffic. A read that matches nothing fetches the byte from memory, returns it, and keeps it in an entry.

Writes always go through to memory. A write that matches an entry also updates the cached byte. A write that matches nothing leaves the cache contents alone and only goes to memory. Free entries are filled first. Once every entry holds a byte, the least recently used entry is replaced. Recency is kept exactly, as one age value per entry.

The requester holds `req_valid` and the request fields steady until `req_done` is high at a clock edge. Memory transfers follow the same rule: a transfer takes place at a clock edge where `mem_valid` and `mem_ready` are both high.

Top module: `fa_wt_cache`

## Requirements
- R1: Reset empties every entry. The first read of any address after reset performs one memory read, even if that address was cached before the reset.
- R2: The tag is the full `ADDR_W`-bit address (4 bits by default). A read whose address equals a cached tag completes with `req_done` high in the cycle the request is presented. It returns the cached byte and makes no memory transfer. Addresses that differ in any single bit do not match.
- R3: A read miss performs exactly one memory read at the request address. It returns the memory byte on `req_rdata` in the cycle of the memory transfer, with `req_done` high in that same cycle.
- R4: While any entry is empty, a read miss fills an empty entry and evicts nothing. After four distinct addresses have been read, all four hit.
- R5: When every entry is valid, a read miss replaces the least recently used entry.
- R6: Every write makes exactly one memory write carrying the request address and data. `req_done` for a write is high only in the cycle the memory accepts it.
- R7: A write whose address is cached also updates the cached byte. A later read of that address returns the new byte with no memory transfer.
- R8: A write that misses allocates nothing and evicts nothing. Every previously cached address still hits afterwards, and a later read of the written address misses.
- R9: With reads alternating between addresses 0x2 and 0x6 from an empty cache, only the first two miss.
- R10: Any hit or fill makes that entry the most recently used one. Only entries more recent than it move one step older, so the entries' ages always form a permutation.
- R11: Once a memory request is raised, it stays raised with address, direction and data unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `req_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (the whole tag) |
| req_wdata | input | DATA_W | Write byte |
| req_done | output | 1 | Request completes at this clock edge |
| req_rdata | output | DATA_W | Read byte, valid with `req_done` on reads |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_ready | input | 1 | Memory accepts the transfer at this edge |
| mem_rdata | input | DATA_W | Memory read byte, valid with `mem_ready` |

## Verification
The hardest situation to reach from the ports is a replacement decision that depends on a recency order built up over many mixed hits and misses. A single eviction only shows whether the victim choice was right or wrong, not why. The stimulus therefore fills the cache, then interleaves hits and misses so that the oldest entry is a different one each time. Each outcome is observed as a memory read, or the absence of one, on a later access. Write misses are placed on a full cache, and every cached address is then re-read to show that nothing was displaced.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

   typedef enum logic [1:0] {
      CTL_IDLE  = 2'd0,
      CTL_FETCH = 2'd1,
      CTL_WSEND = 2'd2
   } ctl_state_e;

   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 4,
   localparam int IDX_W  = fa_cache_pkg::idx_width(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0]              look_tag,
   output logic [ENTRIES-1:0]            hit_vec,
   output logic                          any_hit,
   output logic [IDX_W-1:0]              hit_idx
);

   // one comparator per entry, all evaluated together
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && (ent_tag[g] == look_tag);
   end

   assign any_hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fa_lru_age.sv
module fa_lru_age #(
   parameter int ENTRIES = 4,
   localparam int AGE_W  = fa_cache_pkg::idx_width(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          touch,
   input  logic [AGE_W-1:0]              touch_idx,
   output logic [ENTRIES-1:0][AGE_W-1:0] age,
   output logic [AGE_W-1:0]              oldest_idx
);

   logic [AGE_W-1:0] age_q [ENTRIES];
   logic [AGE_W-1:0] ref_age;

   assign ref_age = age_q[touch_idx];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[g] <= AGE_W'(g);
         end else if (touch) begin
            if (touch_idx == AGE_W'(g)) begin
               age_q[g] <= '0;
            end else if (age_q[g] < ref_age) begin
               age_q[g] <= age_q[g] + 1'b1;
            end
         end
      end
      assign age[g] = age_q[g];
   end

   always_comb begin
      oldest_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (age_q[i] == AGE_W'(ENTRIES - 1)) oldest_idx = AGE_W'(i);
      end
   end

endmodule

// File: rtl/fa_victim_pick.sv
module fa_victim_pick #(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = fa_cache_pkg::idx_width(ENTRIES)
) (
   input  logic [ENTRIES-1:0] ent_valid,
   input  logic [IDX_W-1:0]   oldest_idx,
   output logic [IDX_W-1:0]   victim_idx
);

   logic found;

   // lowest-numbered empty entry first, otherwise the oldest entry
   always_comb begin
      victim_idx = oldest_idx;
      found      = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!found && !ent_valid[i]) begin
            victim_idx = IDX_W'(i);
            found      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fa_wt_cache.sv
module fa_wt_cache #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_done,
   output logic [DATA_W-1:0] req_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   import fa_cache_pkg::*;

   localparam int IDX_W = idx_width(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two and at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   ctl_state_e state_q, state_d;

   logic [ADDR_W-1:0] tag_q  [ENTRIES];
   logic [DATA_W-1:0] data_q [ENTRIES];
   logic              valid_q[ENTRIES];

   logic [ENTRIES-1:0]             valid_vec;
   logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec;
   logic [ENTRIES-1:0]             hit_vec;
   logic [ENTRIES-1:0][IDX_W-1:0]  ent_age;
   logic                           hit;
   logic [IDX_W-1:0]               hit_idx;
   logic [IDX_W-1:0]               oldest_idx;
   logic [IDX_W-1:0]               victim_idx;

   logic rd_hit, fill, wr_done, wr_hit_upd, touch;
   logic [IDX_W-1:0] touch_idx;

   fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W)) i_match (
      .ent_valid(valid_vec),
      .ent_tag  (tag_vec),
      .look_tag (req_addr),
      .hit_vec  (hit_vec),
      .any_hit  (hit),
      .hit_idx  (hit_idx)
   );

   fa_lru_age #(.ENTRIES(ENTRIES)) i_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (touch),
      .touch_idx (touch_idx),
      .age       (ent_age),
      .oldest_idx(oldest_idx)
   );

   fa_victim_pick #(.ENTRIES(ENTRIES)) i_victim (
      .ent_valid (valid_vec),
      .oldest_idx(oldest_idx),
      .victim_idx(victim_idx)
   );

   // completion events
   assign rd_hit     = (state_q == CTL_IDLE) && req_valid && !req_write && hit;
   assign fill       = (state_q == CTL_FETCH) && mem_ready;
   assign wr_done    = (state_q == CTL_WSEND) && mem_ready;
   assign wr_hit_upd = wr_done && hit;
   assign touch      = rd_hit || fill || wr_hit_upd;
   assign touch_idx  = fill ? victim_idx : hit_idx;

   assign req_done  = rd_hit || fill || wr_done;
   assign req_rdata = fill ? mem_rdata : data_q[hit_idx];

   assign mem_valid = (state_q != CTL_IDLE);
   assign mem_write = (state_q == CTL_WSEND);
   assign mem_addr  = req_addr;
   assign mem_wdata = req_wdata;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CTL_IDLE: begin
            if (req_valid) begin
               if (req_write)  state_d = CTL_WSEND;
               else if (!hit)  state_d = CTL_FETCH;
            end
         end
         CTL_FETCH, CTL_WSEND: begin
            if (mem_ready) state_d = CTL_IDLE;
         end
         default: state_d = CTL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CTL_IDLE;
      else        state_q <= state_d;
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic fill_sel, upd_sel;
      assign fill_sel = fill && (victim_idx == IDX_W'(g));
      assign upd_sel  = wr_hit_upd && hit_vec[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tag_q[g]   <= '0;
            data_q[g]  <= '0;
         end else if (fill_sel) begin
            valid_q[g] <= 1'b1;
            tag_q[g]   <= req_addr;
            data_q[g]  <= mem_rdata;
         end else if (upd_sel) begin
            data_q[g]  <= req_wdata;
         end
      end

      assign valid_vec[g] = valid_q[g];
      assign tag_vec[g]   = tag_q[g];
   end

endmodule

// File: rtl/fa_wt_cache_chk.sv
module fa_wt_cache_chk #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   localparam int AGE_W  = fa_cache_pkg::idx_width(ENTRIES)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_done,
   input logic                          req_write,
   input logic                          mem_valid,
   input logic                          mem_write,
   input logic                          mem_ready,
   input logic [ADDR_W-1:0]             mem_addr,
   input logic [DATA_W-1:0]             mem_wdata,
   input logic [ENTRIES-1:0]            hit_vec,
   input logic [ENTRIES-1:0]            valid_vec,
   input logic [ENTRIES-1:0][AGE_W-1:0] ent_age
);

   logic [(1<<AGE_W)-1:0] age_seen;

   always_comb begin
      age_seen = '0;
      for (int i = 0; i < ENTRIES; i++) age_seen[ent_age[i]] = 1'b1;
   end

   // R2
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R10
   age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(age_seen) == ENTRIES);

   // R6
   wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_done && req_write) |-> (mem_valid && mem_write && mem_ready));

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

   // R3
   fill_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_done && !req_write && mem_valid) |-> (hit_vec == '0));

   // R8
   wr_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_done && req_write && (hit_vec == '0)) |=> $stable(valid_vec));

endmodule

bind fa_wt_cache fa_wt_cache_chk #(
   .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_fa_wt_cache_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_done (req_done),
   .req_write(req_write),
   .mem_valid(mem_valid),
   .mem_write(mem_write),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .hit_vec  (hit_vec),
   .valid_vec(valid_vec),
   .ent_age  (ent_age)
);

// File: tb/test_fa_wt_cache.sv
`timescale 1ns/1ps
module test_fa_wt_cache;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_done;
   logic [7:0] req_rdata;
   logic       mem_valid, mem_write;
   logic [3:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_ready = 1'b0;
   logic [7:0] mem_rdata = '0;

   fa_wt_cache i_fa_wt_cache (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   always #10 clk = ~clk;

   typedef struct packed {
      logic       is_read;
      logic [7:0] data;
      logic [1:0] reads;
      logic [1:0] writes;
   } exp_t;

   exp_t  sb_q[$];
   string tag_q[$];

   logic [7:0] ram    [16];
   logic [7:0] shadow [16];
   int mem_lat = 1;
   int wait_cnt = 0;
   int rd_seen = 0;
   int wr_seen = 0;
   int checks = 0;
   int fails = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   // memory responder: raises ready after mem_lat idle cycles
   always begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
         mem_ready = 1'b0;
         wait_cnt  = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
      end else if (mem_valid) begin
         if (wait_cnt >= mem_lat) begin
            mem_ready = 1'b1;
            mem_rdata = ram[mem_addr];
            wait_cnt  = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   // monitor: counts memory transfers, pops the scoreboard on completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_valid && mem_ready) begin
            if (mem_write) begin
               ram[mem_addr] = mem_wdata;
               wr_seen++;
            end else begin
               rd_seen++;
            end
         end
         if (req_done) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected completion", 1, 0);
            end else begin
               exp_t  e;
               string t;
               e = sb_q.pop_front();
               t = tag_q.pop_front();
               chk(rd_seen == int'(e.reads), t, "memory reads", rd_seen, int'(e.reads));
               chk(wr_seen == int'(e.writes), t, "memory writes", wr_seen, int'(e.writes));
               if (e.is_read)
                  chk(req_rdata == e.data, t, "read data", int'(req_rdata), int'(e.data));
            end
            rd_seen = 0;
            wr_seen = 0;
         end
      end
   end

   task automatic access(input bit wr, input logic [3:0] a, input logic [7:0] wd,
                         input bit miss, input string tag);
      exp_t e;
      e.is_read = !wr;
      e.data    = shadow[a];
      e.reads   = (!wr && miss) ? 2'd1 : 2'd0;
      e.writes  = wr ? 2'd1 : 2'd0;
      sb_q.push_back(e);
      tag_q.push_back(tag);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = wd;
      do @(negedge clk); while (!req_done);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (wr) shadow[a] = wd;
   endtask

   task automatic rd(input logic [3:0] a, input bit miss, input string tag);
      access(1'b0, a, 8'h00, miss, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
      access(1'b1, a, d, 1'b0, tag);
      chk(ram[a] == d, "R6", "memory byte after write", int'(ram[a]), int'(d));
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         ram[i]    = 8'(i * 17 + 3);
         shadow[i] = 8'(i * 17 + 3);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(req_done == 1'b0, "R1", "done after reset", int'(req_done), 0);
      chk(mem_valid == 1'b0, "R1", "mem_valid after reset", int'(mem_valid), 0);
      @(posedge clk);
      #1;

      // R9 alternating pattern, R3 misses, R2 hits
      mem_lat = 1;
      rd(4'h2, 1, "R9"); rd(4'h6, 1, "R9");
      for (int k = 0; k < 4; k++) begin
         rd(4'h2, 0, "R9"); rd(4'h6, 0, "R2");
      end

      // R4 free entries filled without eviction
      mem_lat = 0;
      rd(4'h8, 1, "R4"); rd(4'h9, 1, "R4");
      rd(4'h2, 0, "R4"); rd(4'h6, 0, "R4"); rd(4'h8, 0, "R4"); rd(4'h9, 0, "R4");

      // R5 and R10: victims follow the recency order
      mem_lat = 3;
      rd(4'hA, 1, "R5");   // evicts 2
      rd(4'h6, 0, "R10");
      rd(4'h2, 1, "R5");   // evicts 8
      rd(4'h9, 0, "R10");
      rd(4'h8, 1, "R5");   // evicts A
      rd(4'hA, 1, "R5");   // evicts 6
      rd(4'h2, 0, "R10"); rd(4'h9, 0, "R10"); rd(4'h8, 0, "R10"); rd(4'hA, 0, "R10");

      // R7 write hit updates the cached byte
      mem_lat = 1;
      wr(4'h8, 8'h5C, "R7");
      rd(4'h8, 0, "R7");

      // R8 write miss allocates nothing
      wr(4'h3, 8'h3E, "R8");
      rd(4'h2, 0, "R8"); rd(4'h9, 0, "R8"); rd(4'hA, 0, "R8"); rd(4'h8, 0, "R8");
      rd(4'h3, 1, "R8");   // evicts 2
      rd(4'h2, 1, "R5");   // evicts 9

      // R6 write with zero latency
      mem_lat = 0;
      wr(4'h5, 8'hA7, "R6");

      // R1 reset mid-run empties the cache
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      rd(4'h8, 1, "R1");
      rd(4'h8, 0, "R2");
      rd(4'h5, 1, "R1");

      chk(sb_q.size() == 0, "R3", "pending scoreboard items", sb_q.size(), 0);
      done_flag = 1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         chk(1'b0, "R2", "watchdog expired", 1, 0);
         report();
         $finish;
      end
   end

endmodule